// File: doc/BRIEF.md
# Per-Pin Interrupt Trigger Unit

This unit watches a bank of input pins, already synchronised to the local clock, and turns selected pin activity into processor interrupts. Each pin has its own trigger choice made from three single-bit configuration words. A class bit picks edge or level sensing. A polarity bit picks low/falling or high/rising. A dual-edge bit makes an edge-class pin fire on any transition. A per-pin enable decides whether a detected event is recorded in a sticky status word. Software acknowledges an event by writing a one to its status bit.

A single interrupt line is the OR, over all pins, of status bits whose enable is still set. Software programs and inspects the unit through a plain word-wide register port. Writes take effect at the clock edge. Reads are combinational from the address. The register select is an enumerated decode: `SEL_ENABLE`, `SEL_TYPE0`, `SEL_TYPE1`, `SEL_TYPE2`, `SEL_STATUS`, plus `SEL_NONE` for every other address.

Top module: `pin_irq_trigger`

## Requirements
- R1: After reset, the enable, polarity, class, dual-edge and status words all read 0 and `irq_out` is 0. This reset configuration means falling-edge, single-edge sensing with every pin disabled.
- R2: Byte address 0x00 selects the enable word, 0x04 the polarity word (type0), 0x08 the class word (type1), 0x0C the dual-edge word (type2) and 0x10 the status word. Bit i of each word belongs to pin i. The four configuration words read back what was written. Any other address reads 0, including addresses that are not a multiple of 4, and a write to such an address changes nothing.
- R3: With class 0, polarity 0 and dual-edge 0, a 1-to-0 change on an enabled pin sets its status bit at the next clock edge. A 0-to-1 change does not set it.
- R4: With class 0, polarity 1 and dual-edge 0, a 0-to-1 change sets the status bit. A 1-to-0 change does not.
- R5: With class 0 and dual-edge 1, either change sets the status bit, whatever the polarity bit holds.
- R6: With class 1, the status bit is set on every clock edge at which the pin equals the polarity bit (1 means high, 0 means low), and the dual-edge bit has no effect. A clear written while the level persists leaves the bit set. A clear written after the level has gone leaves it at 0.
- R7: An event on a pin whose enable bit is 0 does not set its status bit. Setting the enable later does not record the missed event.
- R8: Writing the status word clears exactly the bits written as 1 and leaves the bits written as 0 unchanged.
- R9: If a clear and a new event reach the same status bit at the same clock edge, the bit ends up set.
- R10: `irq_out` is 1 exactly when some pin has both its status bit and its enable bit set. Clearing the enable masks the interrupt but keeps the status bit.
- R11: Pins are sensed independently, so pins with different trigger settings can react to the same input change with different results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Synchronised pin levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Read data for reg_addr |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench drives a clear and a fresh falling edge into the same bit in one cycle. A design that let the clear win would lose that interrupt. It holds a level-triggered pin asserted while writing a clear, and checks that the bit comes straight back. A design that treated the level as an edge would drop an interrupt that is still pending. It also sends edges to disabled pins and then enables them, which catches a design that records events before gating them. It sends opposite edges to pins configured differently in the same cycle, and sets the dual-edge bit on level pins, to catch polarity or class decode that leaks from one pin or mode into another.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    localparam int unsigned ADDR_W = 5;

    typedef enum logic [2:0] {
        SEL_ENABLE = 3'd0,
        SEL_TYPE0  = 3'd1,
        SEL_TYPE1  = 3'd2,
        SEL_TYPE2  = 3'd3,
        SEL_STATUS = 3'd4,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            5'h00:   s = SEL_ENABLE;
            5'h04:   s = SEL_TYPE0;
            5'h08:   s = SEL_TYPE1;
            5'h0C:   s = SEL_TYPE2;
            5'h10:   s = SEL_STATUS;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [NPINS-1:0]    reg_wdata,
    input  logic [NPINS-1:0]    status_i,
    output logic [NPINS-1:0]    reg_rdata,
    output logic [NPINS-1:0]    enable_o,
    output logic [NPINS-1:0]    type0_o,
    output logic [NPINS-1:0]    type1_o,
    output logic [NPINS-1:0]    type2_o,
    output logic [NPINS-1:0]    clr_o
);

    reg_sel_e         sel;
    logic [NPINS-1:0] enable_q, type0_q, type1_q, type2_q;

    assign sel = decode_addr(reg_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            type0_q  <= '0;
            type1_q  <= '0;
            type2_q  <= '0;
        end else if (reg_wr) begin
            unique case (sel)
                SEL_ENABLE: enable_q <= reg_wdata;
                SEL_TYPE0:  type0_q  <= reg_wdata;
                SEL_TYPE1:  type1_q  <= reg_wdata;
                SEL_TYPE2:  type2_q  <= reg_wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ENABLE: reg_rdata = enable_q;
            SEL_TYPE0:  reg_rdata = type0_q;
            SEL_TYPE1:  reg_rdata = type1_q;
            SEL_TYPE2:  reg_rdata = type2_q;
            SEL_STATUS: reg_rdata = status_i;
            default:    reg_rdata = '0;
        endcase
    end

    assign clr_o    = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;
    assign enable_o = enable_q;
    assign type0_o  = type0_q;
    assign type1_o  = type1_q;
    assign type2_o  = type2_q;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(enable_q) && $stable(type0_q) && $stable(type1_q) && $stable(type2_q))); // R2

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] type0_i,
    input  logic [NPINS-1:0] type1_i,
    input  logic [NPINS-1:0] type2_i,
    output logic [NPINS-1:0] evt_o
);

    logic [NPINS-1:0] pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_i;
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        logic rise, fall, edge_hit, level_hit;
        always_comb begin
            rise      = pin_i[g] & ~pin_q[g];
            fall      = ~pin_i[g] & pin_q[g];
            if (type2_i[g])
                edge_hit = rise | fall;
            else
                edge_hit = type0_i[g] ? rise : fall;
            level_hit = type0_i[g] ? pin_i[g] : ~pin_i[g];
            evt_o[g]  = type1_i[g] ? level_hit : edge_hit;
        end
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & ~type1_i & ~(pin_i ^ pin_q)) == '0)); // R3
    AST_LEVEL_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_o & type1_i & (pin_i ^ type0_i)) == '0)); // R6

endmodule

// File: rtl/pin_irq_status.sv
module pin_irq_status #(
    parameter int unsigned NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt_i,
    input  logic [NPINS-1:0] enable_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] status_o
);

    logic [NPINS-1:0] status_q, set_mask;

    assign set_mask = evt_i & enable_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_i) | set_mask;
    end

    assign status_o = status_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(clr_i & ~set_mask)) == '0)); // R8
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(set_mask)) == $past(set_mask))); // R9
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i & enable_i)) == '0)); // R7

endmodule

// File: rtl/pin_irq_trigger.sv
module pin_irq_trigger
    import pin_irq_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq_out
);

    logic [NPINS-1:0] enable_w, type0_w, type1_w, type2_w, clr_w, evt_w, status_w;

    pin_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status_i(status_w), .reg_rdata(reg_rdata),
        .enable_o(enable_w), .type0_o(type0_w), .type1_o(type1_w),
        .type2_o(type2_w), .clr_o(clr_w)
    );

    pin_irq_detect #(.NPINS(NPINS)) u_detect (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .type0_i(type0_w),
        .type1_i(type1_w), .type2_i(type2_w), .evt_o(evt_w)
    );

    pin_irq_status #(.NPINS(NPINS)) u_status (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_w), .enable_i(enable_w),
        .clr_i(clr_w), .status_o(status_w)
    );

    assign irq_out = |(status_w & enable_w);

    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status_w != '0)); // R10

endmodule

// File: tb/pin_irq_trigger_tb.sv
`timescale 1ns/1ps
module pin_irq_trigger_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pin_in = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [4:0] A_EN = 5'h00, A_T0 = 5'h04, A_T1 = 5'h08,
                           A_T2 = 5'h0C, A_ST = 5'h10;

    pin_irq_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    always #2 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        step();
        reg_wr    = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic restore();
        wr(A_EN, '0);
        wr(A_T0, '0);
        wr(A_T1, '0);
        wr(A_T2, '0);
        pin_in = '0;
        step();
        wr(A_ST, '1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_EN, d); check("R1", "enable", d, 0);
        rd(A_T0, d); check("R1", "type0", d, 0);
        rd(A_T1, d); check("R1", "type1", d, 0);
        rd(A_T2, d); check("R1", "type2", d, 0);
        rd(A_ST, d); check("R1", "status", d, 0);
        check("R1", "irq", {31'b0, irq_out}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(A_EN, 32'hA5A5_0F0F); rd(A_EN, d); check("R2", "enable rb", d, 32'hA5A5_0F0F);
        wr(A_EN, '0);
        wr(A_T0, 32'h1234_5678); rd(A_T0, d); check("R2", "type0 rb", d, 32'h1234_5678);
        wr(A_T1, 32'h0F0F_F0F0); rd(A_T1, d); check("R2", "type1 rb", d, 32'h0F0F_F0F0);
        wr(A_T2, 32'hDEAD_BEEF); rd(A_T2, d); check("R2", "type2 rb", d, 32'hDEAD_BEEF);
        wr(5'h14, 32'hFFFF_FFFF); wr(5'h05, 32'hFFFF_FFFF);
        rd(5'h14, d); check("R2", "unmapped read", d, 0);
        rd(5'h05, d); check("R2", "misaligned read", d, 0);
        rd(A_T0, d); check("R2", "type0 after stray", d, 32'h1234_5678);
        rd(A_EN, d); check("R2", "enable after stray", d, 0);
        restore();
    endtask

    task automatic t_fall();
        logic [31:0] d;
        wr(A_EN, 32'h8);
        pin_in[3] = 1'b1; step();
        rd(A_ST, d); check("R3", "rise ignored", d, 0);
        pin_in[3] = 1'b0; step();
        rd(A_ST, d); check("R3", "fall sets", d, 32'h8);
        check("R10", "irq on", {31'b0, irq_out}, 1);
        restore();
    endtask

    task automatic t_rise();
        logic [31:0] d;
        wr(A_T0, 32'h20); wr(A_EN, 32'h20);
        pin_in[5] = 1'b1; step();
        rd(A_ST, d); check("R4", "rise sets", d, 32'h20);
        wr(A_ST, 32'h20);
        pin_in[5] = 1'b0; step();
        rd(A_ST, d); check("R4", "fall ignored", d, 0);
        restore();
    endtask

    task automatic t_both();
        logic [31:0] d;
        wr(A_T2, 32'h80); wr(A_EN, 32'h80);
        pin_in[7] = 1'b1; step();
        rd(A_ST, d); check("R5", "rise sets", d, 32'h80);
        wr(A_ST, 32'h80);
        pin_in[7] = 1'b0; step();
        rd(A_ST, d); check("R5", "fall sets", d, 32'h80);
        wr(A_ST, 32'h80); wr(A_T0, 32'h80);
        pin_in[7] = 1'b1; step();
        rd(A_ST, d); check("R5", "rise polarity1", d, 32'h80);
        wr(A_ST, 32'h80);
        pin_in[7] = 1'b0; step();
        rd(A_ST, d); check("R5", "fall polarity1", d, 32'h80);
        restore();
    endtask

    task automatic t_level();
        logic [31:0] d;
        wr(A_T1, 32'h200); wr(A_T0, 32'h200); wr(A_EN, 32'h200);
        pin_in[9] = 1'b1; step();
        rd(A_ST, d); check("R6", "high level sets", d, 32'h200);
        wr(A_ST, 32'h200);
        rd(A_ST, d); check("R6", "clear while held", d, 32'h200);
        pin_in[9] = 1'b0; step();
        rd(A_ST, d); check("R6", "sticky after release", d, 32'h200);
        wr(A_ST, 32'h200);
        rd(A_ST, d); check("R6", "clear after release", d, 0);
        restore();
        wr(A_T1, 32'h400); wr(A_T2, 32'h400); wr(A_EN, 32'h400);
        step();
        rd(A_ST, d); check("R6", "low level sets", d, 32'h400);
        pin_in[10] = 1'b1; step();
        wr(A_ST, 32'h400);
        rd(A_ST, d); check("R6", "dual-edge bit ignored in level", d, 0);
        restore();
    endtask

    task automatic t_gate();
        logic [31:0] d;
        pin_in[12] = 1'b1; step();
        pin_in[12] = 1'b0; step();
        rd(A_ST, d); check("R7", "disabled edge", d, 0);
        check("R7", "disabled irq", {31'b0, irq_out}, 0);
        wr(A_EN, 32'h1000); step();
        rd(A_ST, d); check("R7", "no late record", d, 0);
        restore();
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(A_EN, 32'h28); wr(A_T0, 32'h20);
        pin_in[3] = 1'b1; pin_in[5] = 1'b1; step();
        pin_in[3] = 1'b0; step();
        rd(A_ST, d); check("R8", "both set", d, 32'h28);
        wr(A_ST, 32'h8);
        rd(A_ST, d); check("R8", "partial clear", d, 32'h20);
        wr(A_ST, 32'h0);
        rd(A_ST, d); check("R8", "zero write", d, 32'h20);
        restore();
    endtask

    task automatic t_race();
        logic [31:0] d;
        wr(A_EN, 32'hC000);
        pin_in[15] = 1'b1; step();
        pin_in[15] = 1'b0; pin_in[14] = 1'b1; step();
        rd(A_ST, d); check("R9", "pre-set", d, 32'h8000);
        pin_in[14] = 1'b0;
        wr(A_ST, 32'hC000);
        rd(A_ST, d); check("R9", "event beats clear", d, 32'h4000);
        restore();
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(A_EN, 32'h8);
        pin_in[3] = 1'b1; step();
        pin_in[3] = 1'b0; step();
        check("R10", "irq set", {31'b0, irq_out}, 1);
        wr(A_EN, 32'h0);
        #0.5;
        check("R10", "irq masked", {31'b0, irq_out}, 0);
        rd(A_ST, d); check("R10", "status kept", d, 32'h8);
        wr(A_EN, 32'h8);
        #0.5;
        check("R10", "irq back", {31'b0, irq_out}, 1);
        restore();
        check("R10", "irq after clear", {31'b0, irq_out}, 0);
    endtask

    task automatic t_indep();
        logic [31:0] d;
        wr(A_T0, 32'h2); wr(A_T2, 32'h4); wr(A_EN, 32'h7);
        pin_in[2:0] = 3'b111; step();
        rd(A_ST, d); check("R11", "mixed rise", d, 32'h6);
        wr(A_ST, '1);
        pin_in[2:0] = 3'b000; step();
        rd(A_ST, d); check("R11", "mixed fall", d, 32'h5);
        restore();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_fall();
        t_rise();
        t_both();
        t_level();
        t_gate();
        t_w1c();
        t_race();
        t_mask();
        t_indep();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule